// File: doc/BRIEF.md
# Storage-Backed Loadable Shift Register

This block pairs a WIDTH-bit input storage register with a WIDTH-bit shift register. A single bidirectional parallel port serves both. It is an input to the storage register and to the shift register's direct load, and an output for the shift register's stages. The shift register can be cleared, loaded straight from the port, loaded from the storage register, or shifted right. One of two serial inputs feeds stage 0, picked by a select line. The last stage is always visible on a serial output.

The design is fully synchronous. Every input pin, the pin "clocks" included, passes through a SYNC_STAGES-deep synchroniser on the system clock. A small two-state machine per pin clock (states EDG_LOW and EDG_HIGH) turns a low sample followed by a high sample into a one-cycle rising event. The move EDG_LOW to EDG_HIGH raises the event, the move EDG_HIGH to EDG_LOW is silent, and a state that holds raises nothing.

In each cycle the shift core picks exactly one operating mode. The modes in priority order are MD_CLEAR, MD_XFER, MD_DIRECT, MD_SHIFT and MD_HOLD, and the chosen mode decides the next register contents. The tri-state port appears as three signals: `port_out` carries the data, `port_drive` is the enable, and `port_in` returns the resolved bus.

Top module: `sbsr_top`

## Requirements
- R1: While the system reset `rst_n` is low, `port_out` and `ser_out` are all zeros and `port_drive` is 1.
- R2: While `clear_n` is low, the shift register becomes all zeros, whatever the load, shift clock and storage clock inputs are doing.
- R3: While `shf_clk` is low, `load_n` is low and `stor_clk` has no rising edge, the shift register loads the value on `port_in` in every cycle.
- R4: While `shf_clk` is high, a low `load_n` has no effect on the shift register.
- R5: A rising edge on `shf_clk` with `load_n` high and `shf_en_n` low shifts right. Stage i takes stage i-1, and with `ser_sel` = 0 stage 0 takes `ser_in0`.
- R6: With `ser_sel` = 1, a shift places `ser_in1` in stage 0.
- R7: While `shf_en_n` is high, rising edges on `shf_clk` leave the shift register unchanged.
- R8: Every rising edge of `stor_clk` captures `port_in` into the storage register.
- R9: A rising edge of `stor_clk` while `shf_clk` is low and `load_n` is low loads the shift register with the storage contents held before that edge.
- R10: While `port_hiz` is high, `port_drive` is 0. Shifting, loading and clearing continue, and `ser_out` keeps showing the last stage.
- R11: `ser_out` equals the most significant stage of the shift register, which `port_out` presents at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| port_in | input | WIDTH | Resolved value of the parallel port |
| port_out | output | WIDTH | Shift register stages, driven onto the port |
| port_drive | output | 1 | High when the block drives the port |
| stor_clk | input | 1 | Storage clock pin; its rising edge captures the port |
| shf_clk | input | 1 | Shift clock pin; its level gates loads, its rising edge shifts |
| shf_en_n | input | 1 | Active-low shift enable |
| load_n | input | 1 | Active-low load request |
| clear_n | input | 1 | Active-low shift register clear |
| ser_sel | input | 1 | Serial source select: 0 picks ser_in0, 1 picks ser_in1 |
| ser_in0 | input | 1 | Serial input 0 |
| ser_in1 | input | 1 | Serial input 1 |
| port_hiz | input | 1 | High floats the parallel port |
| ser_out | output | 1 | Last shift register stage |

## Verification
The assertions check the mode decision in every cycle. Clear zeroes the register, a shift moves the previous contents up by one stage with the chosen serial bit, a transfer copies the prior storage value, a direct load copies the port, and a load attempted while the shift clock is high leaves the register stable. Only the bench scenarios can show the properties that depend on the path from pins to register. These are the sweep of all port values through the direct load, the serial input select, the ordering that makes a transfer deliver the old storage contents while the storage register captures new ones, and the floating of the port while activity continues behind it.

// File: rtl/sbsr_pkg.sv
package sbsr_pkg;
    typedef enum logic [2:0] {
        MD_CLEAR  = 3'd0,
        MD_XFER   = 3'd1,
        MD_DIRECT = 3'd2,
        MD_SHIFT  = 3'd3,
        MD_HOLD   = 3'd4
    } sbsr_mode_e;

    typedef enum logic {
        EDG_LOW  = 1'b0,
        EDG_HIGH = 1'b1
    } edge_state_e;
endpackage

// File: rtl/sbsr_sync.sv
module sbsr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbsr_edge.sv
module sbsr_edge
    import sbsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    edge_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EDG_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        rise     = 1'b0;
        unique case (state)
            EDG_LOW: begin
                if (lvl) begin
                    state_nx = EDG_HIGH;
                    rise     = 1'b1;
                end
            end
            EDG_HIGH: begin
                if (!lvl) state_nx = EDG_LOW;
            end
            default: state_nx = EDG_LOW;
        endcase
    end

    // R5
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sbsr_stor.sv
module sbsr_stor #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (cap) q <= d;
    end
endmodule

// File: rtl/sbsr_core.sv
module sbsr_core
    import sbsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             sck_lvl,
    input  logic             sck_rise,
    input  logic             sen_n,
    input  logic             ld_n,
    input  logic             st_rise,
    input  logic             ser_bit,
    input  logic [WIDTH-1:0] par_in,
    input  logic [WIDTH-1:0] stor_q,
    output logic [WIDTH-1:0] q
);
    sbsr_mode_e       mode;
    logic [WIDTH-1:0] q_nx;

    always_comb begin
        if (!clr_n)                           mode = MD_CLEAR;
        else if (!sck_lvl && !ld_n && st_rise) mode = MD_XFER;
        else if (!sck_lvl && !ld_n)            mode = MD_DIRECT;
        else if (sck_rise && ld_n && !sen_n)   mode = MD_SHIFT;
        else                                   mode = MD_HOLD;
    end

    always_comb begin
        q_nx = q;
        unique case (mode)
            MD_CLEAR:  q_nx = '0;
            MD_XFER:   q_nx = stor_q;
            MD_DIRECT: q_nx = par_in;
            MD_SHIFT:  q_nx = {q[WIDTH-2:0], ser_bit};
            MD_HOLD:   q_nx = q;
            default:   q_nx = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nx;
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (q == '0));

    // R5
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && sck_rise && !sen_n)
        |=> (q == {$past(q[WIDTH-2:0]), $past(ser_bit)}));

    // R9
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !sck_lvl && !ld_n && st_rise) |=> (q == $past(stor_q)));

    // R3
    direct_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !sck_lvl && !ld_n && !st_rise) |=> (q == $past(par_in)));

    // R4
    load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && sck_lvl && !ld_n) |=> $stable(q));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ld_n && !(sck_rise && !sen_n)) |=> $stable(q));
endmodule

// File: rtl/sbsr_top.sv
module sbsr_top #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] port_in,
    output logic [WIDTH-1:0] port_out,
    output logic             port_drive,
    input  logic             stor_clk,
    input  logic             shf_clk,
    input  logic             shf_en_n,
    input  logic             load_n,
    input  logic             clear_n,
    input  logic             ser_sel,
    input  logic             ser_in0,
    input  logic             ser_in1,
    input  logic             port_hiz,
    output logic             ser_out
);
    localparam int NCTL = 9;
    localparam int SW   = WIDTH + NCTL;

    logic [SW-1:0]    raw_v, syn_v;
    logic [WIDTH-1:0] par_s, stor_q, q;
    logic st_s, sck_s, sen_s, ld_s, clr_s, sel_s, s0_s, s1_s, hiz_s;
    logic st_rise, sck_rise, ser_bit;

    // Inverted on entry so that the synchroniser's zero reset reads as
    // "released" for the active-low pins and "driving" for the float pin.
    assign raw_v = {port_in, stor_clk, shf_clk, ~shf_en_n, ~load_n,
                    ~clear_n, ser_sel, ser_in0, ser_in1, port_hiz};

    sbsr_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
    );

    logic sen_a, ld_a, clr_a;
    assign {par_s, st_s, sck_s, sen_a, ld_a, clr_a, sel_s, s0_s, s1_s, hiz_s} = syn_v;
    assign sen_s = ~sen_a;
    assign ld_s  = ~ld_a;
    assign clr_s = ~clr_a;

    sbsr_edge u_st_edge (.clk(clk), .rst_n(rst_n), .lvl(st_s),  .rise(st_rise));
    sbsr_edge u_sk_edge (.clk(clk), .rst_n(rst_n), .lvl(sck_s), .rise(sck_rise));

    sbsr_stor #(.WIDTH(WIDTH)) u_stor (
        .clk(clk), .rst_n(rst_n), .cap(st_rise), .d(par_s), .q(stor_q)
    );

    assign ser_bit = sel_s ? s1_s : s0_s;

    sbsr_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_s), .sck_lvl(sck_s),
        .sck_rise(sck_rise), .sen_n(sen_s), .ld_n(ld_s), .st_rise(st_rise),
        .ser_bit(ser_bit), .par_in(par_s), .stor_q(stor_q), .q(q)
    );

    assign port_out   = q;
    assign ser_out    = q[WIDTH-1];
    assign port_drive = ~hiz_s;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (port_out == '0 && port_drive));
endmodule

// File: tb/sbsr_top_bench.sv
module sbsr_top_bench;
    localparam int W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic [W-1:0] ext_val = '0;
    logic [W-1:0] port_in, port_out;
    logic port_drive, ser_out;
    logic stor_clk = 0, shf_clk = 0, shf_en_n = 0, load_n = 1, clear_n = 1;
    logic ser_sel = 0, ser_in0 = 0, ser_in1 = 0, port_hiz = 0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [W-1:0] exp_q = '0;

    always #5 clk = ~clk;

    assign port_in = port_drive ? port_out : ext_val;

    sbsr_top #(.WIDTH(W), .SYNC_STAGES(2)) u_sbsr_top (
        .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_out(port_out),
        .port_drive(port_drive), .stor_clk(stor_clk), .shf_clk(shf_clk),
        .shf_en_n(shf_en_n), .load_n(load_n), .clear_n(clear_n),
        .ser_sel(ser_sel), .ser_in0(ser_in0), .ser_in1(ser_in1),
        .port_hiz(port_hiz), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic shf_pulse();
        shf_clk = 1; settle();
        shf_clk = 0; settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 port_out", port_out, '0);
        check("R1 ser_out", {7'b0, ser_out}, 8'h00);
        check("R1 port_drive", {7'b0, port_drive}, 8'h01);
        rst_n = 1;
        settle();

        // R3: sweep every port value through the direct load
        port_hiz = 1; settle();
        check("R10 drive off", {7'b0, port_drive}, 8'h00);
        load_n = 0;
        for (int v = 0; v < 256; v++) begin
            ext_val = v[W-1:0]; settle();
            check("R3 direct load", port_out, v[W-1:0]);
        end
        load_n = 1; settle();
        exp_q = 8'hFF;

        // R5 / R6 / R11: serial shifting from each source
        for (int sel = 0; sel < 2; sel++) begin
            ser_sel = sel[0];
            for (int i = 0; i < 16; i++) begin
                logic b;
                b = ((8'hB5 >> (i % 8)) & 1) != 0;
                if (i >= 8) b = ~b;
                ser_in0 = sel ? ~b : b;
                ser_in1 = sel ? b : ~b;
                shf_pulse();
                exp_q = {exp_q[W-2:0], b};
                check(sel ? "R6 shift sel1" : "R5 shift sel0", port_out, exp_q);
                check("R11 ser_out", {7'b0, ser_out}, {7'b0, exp_q[W-1]});
            end
        end

        // R7: disabled shift clock
        shf_en_n = 1; ser_in0 = ~exp_q[0]; ser_sel = 0;
        shf_pulse(); shf_pulse();
        check("R7 shift disabled", port_out, exp_q);

        // R4: load locked while shift clock high
        shf_clk = 1; settle();
        ext_val = ~exp_q; load_n = 0; settle();
        check("R4 load locked", port_out, exp_q);
        load_n = 1; settle();
        shf_clk = 0; settle();
        check("R4 after release", port_out, exp_q);
        shf_en_n = 0;

        // R2: clear overrides shift and direct load
        clear_n = 0; ser_in0 = 1; shf_pulse();
        exp_q = '0;
        check("R2 clear over shift", port_out, exp_q);
        ext_val = 8'h5A; load_n = 0; settle();
        check("R2 clear over load", port_out, exp_q);
        load_n = 1; clear_n = 1; settle();
        check("R2 clear released", port_out, exp_q);

        // R8 / R9: storage capture and transfer
        shf_en_n = 1;
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] a;
            a = (k == 0) ? 8'h3C : (k == 1) ? 8'hA5 : (k == 2) ? 8'hFF : 8'h01;
            shf_clk = 1; ext_val = a; settle();
            stor_clk = 1; settle(); stor_clk = 0; settle();
            ext_val = ~a;
            @(negedge clk); shf_clk = 0; load_n = 0; stor_clk = 1;
            @(negedge clk); load_n = 1;
            settle();
            check("R9 transfer old storage", port_out, a);
            stor_clk = 0; shf_clk = 1; settle();
            @(negedge clk); shf_clk = 0; load_n = 0; stor_clk = 1;
            @(negedge clk); load_n = 1;
            settle();
            check("R8 capture at transfer edge", port_out, ~a);
            stor_clk = 0; settle();
            exp_q = ~a;
        end
        shf_en_n = 0;

        // R10: activity behind a floating port
        ser_sel = 1; ser_in1 = ~exp_q[W-1];
        shf_pulse();
        exp_q = {exp_q[W-2:0], ser_in1};
        check("R10 shift while floating", port_out, exp_q);
        check("R10 ser_out while floating", {7'b0, ser_out}, {7'b0, exp_q[W-1]});
        port_hiz = 0; settle();
        check("R10 drive on", {7'b0, port_drive}, 8'h01);
        ext_val = ~exp_q; load_n = 0; settle();
        check("R3 load of own driven value", port_out, exp_q);
        load_n = 1; settle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule